// File: doc/BRIEF.md
# Paged Program Address Translator

This block converts a 16-bit CPU-local address into a 23-bit global program-flash address. The local map is split into four 16KB quarters, selected by local bits [15:14]. The lowest quarter is left untranslated. The second quarter always lands on page 0xFD. The top quarter always lands on page 0xFF. The third quarter, 0x8000 to 0xBFFF, is a movable window: an 8-bit page index register picks which of 256 pages of 16KB appears there. Together the pages cover 4MB of program space.

The page index has two write paths. The first is a register bus that can write and read the index at any time, at a single register address. The second is a priority load port, used by call and return sequences, which writes the index directly. Reset sets the index to 0xFE. As a result, local 0x4000 to 0xFFFF reads as one linear run of flash, pages 0xFD, 0xFE and 0xFF, without any setup. Each access presented with the valid strobe produces a registered global address and a flash-hit flag one clock later.

Top module: `prog_page_xlat`

## Requirements
- R1: A synchronous active-high reset sets the page index to 0xFE, so that after reset a read of the index returns 0xFE and local 0x8000 maps to global 0x7F8000.
- R2: A local address in 0x8000–0xBFFF maps to global {1'b1, index[7:0], local[13:0]}, with the flash-hit flag set.
- R3: A local address in 0xC000–0xFFFF maps to global {1'b1, 8'hFF, local[13:0]} whatever the index holds, with the flash-hit flag set.
- R4: A local address in 0x4000–0x7FFF maps to global {1'b1, 8'hFD, local[13:0]}, with the flash-hit flag set.
- R5: A local address below 0x4000 is not translated: the flash-hit flag is 0 and the global address is 0, while the result-valid output is still 1.
- R6: Every flash mapping drives global bit 22 to 1 and passes local bits [13:0] unchanged into global bits [13:0].
- R7: A register-bus write with bus address 0x0016 loads the write data into the index at the clock edge that samples it. A write to any other bus address leaves the index unchanged.
- R8: A register-bus read with bus address 0x0016 returns the index on the read-data output in the following cycle. A read of any other address, and any cycle without a read, returns 0.
- R9: A priority load writes its data into the index at the next clock edge. When it coincides with a register-bus write, the priority data is the value that ends up in the index.
- R10: Results are registered. The global address, flash-hit flag and result-valid output reflect the access sampled at the previous edge. In a cycle after an edge that sampled no valid access, all three are 0.
- R11: An access sampled at the same edge as an index write is translated with the old index. The next access uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_addr | input | 16 | CPU-local address |
| loc_valid | input | 1 | Access strobe for loc_addr |
| bus_addr | input | 16 | Register-bus address |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_rd | input | 1 | Register-bus read strobe |
| bus_wdata | input | 8 | Register-bus write data |
| bus_rdata | output | 8 | Register-bus read data, one cycle after bus_rd |
| prio_load | input | 1 | Priority index load strobe |
| prio_data | input | 8 | Priority index load data |
| glob_addr | output | 23 | Translated global address |
| flash_hit | output | 1 | Access lands in program flash |
| out_valid | output | 1 | Registered result is valid |

## Verification
The bench writes every one of the 256 index values and checks each against an address inside the window. This would expose a design that drops or swaps index bits. At every index it also checks the top quarter, so a design that lets the index leak into the top page is caught. A sweep across the whole local space hits each quarter boundary (0x3FFF/0x4000, 0x7FFF/0x8000, 0xBFFF/0xC000). Off-by-one region decoding, or a lowest quarter that is wrongly reported as flash, would show up at those boundaries. Directed cases cover a collision between the two write paths, where a design with the wrong priority keeps the bus data. They also cover a write to a neighbouring register address, which a loose decode would accept. A write in the same cycle as an access checks that a design reading the new index too early translates that access with the wrong page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_LOW   = 2'd1,
    RG_PAGED = 2'd2,
    RG_TOP   = 2'd3
  } region_e;

  function automatic region_e region_of(input logic [1:0] quarter);
    case (quarter)
      2'd1:    return RG_LOW;
      2'd2:    return RG_PAGED;
      2'd3:    return RG_TOP;
      default: return RG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/page_index_reg.sv
module page_index_reg #(
  parameter int          PAGE_W     = 8,
  parameter int          BUS_AW     = 16,
  parameter logic [BUS_AW-1:0] REG_ADDR = 16'h0016,
  parameter logic [PAGE_W-1:0] RESET_PG = 8'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PAGE_W-1:0] bus_wdata,
  input  logic              prio_load,
  input  logic [PAGE_W-1:0] prio_data,
  output logic [PAGE_W-1:0] idx_q,
  output logic [PAGE_W-1:0] rdata_q
);
  logic sel;
  assign sel = (bus_addr == REG_ADDR);

  // priority load is checked first so it wins a collision
  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= RESET_PG;
    else if (prio_load)
      idx_q <= prio_data;
    else if (bus_wr && sel)
      idx_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (bus_rd && sel)
      rdata_q <= idx_q;
    else
      rdata_q <= '0;
  end
endmodule

// File: rtl/region_map.sv
module region_map
  import xlat_pkg::*;
#(
  parameter int LA_W   = 16,
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] LOW_PG = 8'hFD,
  parameter logic [PAGE_W-1:0] TOP_PG = 8'hFF,
  localparam int OFF_W = LA_W - 2,
  localparam int GA_W  = OFF_W + PAGE_W + 1
) (
  input  logic [LA_W-1:0]   loc_addr,
  input  logic [PAGE_W-1:0] idx,
  output logic [GA_W-1:0]   gaddr,
  output logic              hit
);
  region_e              rg;
  logic [PAGE_W-1:0]    page;

  assign rg = region_of(loc_addr[LA_W-1 -: 2]);

  always_comb begin
    page = '0;
    hit  = 1'b1;
    case (rg)
      RG_LOW:   page = LOW_PG;
      RG_PAGED: page = idx;
      RG_TOP:   page = TOP_PG;
      default:  hit  = 1'b0;
    endcase
    gaddr = hit ? {1'b1, page, loc_addr[OFF_W-1:0]} : '0;
  end
endmodule

// File: rtl/prog_page_xlat.sv
module prog_page_xlat #(
  parameter int LA_W   = 16,
  parameter int PAGE_W = 8,
  parameter int BUS_AW = 16,
  parameter logic [BUS_AW-1:0] REG_ADDR = 16'h0016,
  parameter logic [PAGE_W-1:0] RESET_PG = 8'hFE,
  parameter logic [PAGE_W-1:0] LOW_PG   = 8'hFD,
  parameter logic [PAGE_W-1:0] TOP_PG   = 8'hFF,
  localparam int GA_W = LA_W - 2 + PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LA_W-1:0]   loc_addr,
  input  logic              loc_valid,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PAGE_W-1:0] bus_wdata,
  output logic [PAGE_W-1:0] bus_rdata,
  input  logic              prio_load,
  input  logic [PAGE_W-1:0] prio_data,
  output logic [GA_W-1:0]   glob_addr,
  output logic              flash_hit,
  output logic              out_valid
);
  logic [PAGE_W-1:0] idx;
  logic [GA_W-1:0]   map_addr;
  logic              map_hit;

  page_index_reg #(
    .PAGE_W(PAGE_W), .BUS_AW(BUS_AW), .REG_ADDR(REG_ADDR), .RESET_PG(RESET_PG)
  ) u_idx (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .prio_load(prio_load), .prio_data(prio_data),
    .idx_q(idx), .rdata_q(bus_rdata)
  );

  region_map #(
    .LA_W(LA_W), .PAGE_W(PAGE_W), .LOW_PG(LOW_PG), .TOP_PG(TOP_PG)
  ) u_map (
    .loc_addr(loc_addr), .idx(idx), .gaddr(map_addr), .hit(map_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_addr <= '0;
      flash_hit <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= loc_valid;
      flash_hit <= loc_valid & map_hit;
      glob_addr <= loc_valid ? map_addr : '0;
    end
  end
endmodule

// File: rtl/prog_page_xlat_chk.sv
module prog_page_xlat_chk #(
  parameter int LA_W   = 16,
  parameter int PAGE_W = 8,
  parameter int BUS_AW = 16,
  parameter logic [BUS_AW-1:0] REG_ADDR = 16'h0016,
  parameter logic [PAGE_W-1:0] RESET_PG = 8'hFE,
  parameter logic [PAGE_W-1:0] LOW_PG   = 8'hFD,
  parameter logic [PAGE_W-1:0] TOP_PG   = 8'hFF,
  localparam int OFF_W = LA_W - 2,
  localparam int GA_W  = OFF_W + PAGE_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [LA_W-1:0]   loc_addr,
  input logic              loc_valid,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [PAGE_W-1:0] bus_wdata,
  input logic [PAGE_W-1:0] bus_rdata,
  input logic              prio_load,
  input logic [PAGE_W-1:0] prio_data,
  input logic [GA_W-1:0]   glob_addr,
  input logic              flash_hit,
  input logic              out_valid,
  input logic [PAGE_W-1:0] idx
);
  a_r1_reset_index: assert property (@(posedge clk) rst |=> idx == RESET_PG);

  a_r3_top_fixed: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_addr[LA_W-1 -: 2] == 2'd3) |=>
      (flash_hit && glob_addr[GA_W-2 -: PAGE_W] == TOP_PG));

  a_r4_low_fixed: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_addr[LA_W-1 -: 2] == 2'd1) |=>
      (flash_hit && glob_addr[GA_W-2 -: PAGE_W] == LOW_PG));

  a_r5_untranslated: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_addr[LA_W-1 -: 2] == 2'd0) |=>
      (!flash_hit && glob_addr == '0 && out_valid));

  a_r6_offset_pass: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_addr[LA_W-1 -: 2] != 2'd0) |=>
      (glob_addr[GA_W-1] && glob_addr[OFF_W-1:0] == $past(loc_addr[OFF_W-1:0])));

  a_r7_bus_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR && !prio_load) |=> idx == $past(bus_wdata));

  a_r7_other_addr: assert property (@(posedge clk) disable iff (rst)
    (!prio_load && !(bus_wr && bus_addr == REG_ADDR)) |=> $stable(idx));

  a_r8_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_ADDR) |=> bus_rdata == $past(idx));

  a_r9_prio_wins: assert property (@(posedge clk) disable iff (rst)
    prio_load |=> idx == $past(prio_data));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !loc_valid |=> (!out_valid && !flash_hit && glob_addr == '0));
endmodule

bind prog_page_xlat prog_page_xlat_chk #(
  .LA_W(LA_W), .PAGE_W(PAGE_W), .BUS_AW(BUS_AW), .REG_ADDR(REG_ADDR),
  .RESET_PG(RESET_PG), .LOW_PG(LOW_PG), .TOP_PG(TOP_PG)
) u_chk (
  .clk(clk), .rst(rst), .loc_addr(loc_addr), .loc_valid(loc_valid),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .prio_load(prio_load), .prio_data(prio_data),
  .glob_addr(glob_addr), .flash_hit(flash_hit), .out_valid(out_valid), .idx(idx)
);

// File: tb/test_prog_page_xlat.sv
module test_prog_page_xlat;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] loc_addr = '0;
  logic        loc_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        prio_load = 1'b0;
  logic [7:0]  prio_data = '0;
  logic [22:0] glob_addr;
  logic        flash_hit;
  logic        out_valid;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_page_xlat i_prog_page_xlat (
    .clk(clk), .rst(rst), .loc_addr(loc_addr), .loc_valid(loc_valid),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .prio_load(prio_load), .prio_data(prio_data),
    .glob_addr(glob_addr), .flash_hit(flash_hit), .out_valid(out_valid)
  );

  function automatic logic [23:0] expect_map(input logic [15:0] a, input logic [7:0] pg);
    logic [7:0] p;
    case (a[15:14])
      2'd0: return 24'd0;
      2'd1: p = 8'hFD;
      2'd2: p = pg;
      default: p = 8'hFF;
    endcase
    return {1'b1, 1'b1, p, a[13:0]};  // {hit, global[22:0]}
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic [7:0] pg, input string req);
    logic [23:0] e;
    e = expect_map(a, pg);
    @(negedge clk);
    loc_addr = a; loc_valid = 1'b1;
    @(negedge clk);
    loc_valid = 1'b0;
    check(out_valid == 1'b1, req, out_valid, 1);
    check({flash_hit, glob_addr} == e, req, {flash_hit, glob_addr}, e);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata == e, req, bus_rdata, e);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] cur;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state of outputs
    check({out_valid, flash_hit, glob_addr} == 25'd0, "R10 reset outputs",
          {out_valid, flash_hit, glob_addr}, 0);
    // R1 / R8: reset index read back and used
    bus_read(16'h0016, 8'hFE, "R1 reset readback");
    access(16'h8000, 8'hFE, "R1 reset mapping");
    // R2..R6 boundaries with reset index
    access(16'h3FFF, 8'hFE, "R5 below boundary");
    access(16'h0000, 8'hFE, "R5 zero");
    access(16'h4000, 8'hFE, "R4 low start");
    access(16'h7FFF, 8'hFE, "R4 low end");
    access(16'hBFFF, 8'hFE, "R2 window end");
    access(16'hC000, 8'hFE, "R3 top start");
    access(16'hFFFF, 8'hFE, "R3 top end");
    // R6: sweep the local space
    for (int a = 0; a < 65536; a += 16'h0123)
      access(a[15:0], 8'hFE, "R6 sweep");
    // R10: idle after an access
    @(negedge clk);
    check({out_valid, flash_hit, glob_addr} == 25'd0, "R10 idle outputs",
          {out_valid, flash_hit, glob_addr}, 0);
    // R7 / R2 / R3: every index value
    for (int p = 0; p < 256; p++) begin
      bus_write(16'h0016, p[7:0]);
      access(16'h8000 | ((p * 16'h0025) & 16'h3FFF), p[7:0], "R2 page sweep");
      access(16'hC000 + p[15:0], p[7:0], "R3 top ignores index");
      if (p % 16 == 5) bus_read(16'h0016, p[7:0], "R8 readback sweep");
    end
    cur = 8'hFF;
    // R7: neighbouring address ignored
    bus_write(16'h0017, 8'h12);
    bus_write(16'h0015, 8'h34);
    access(16'h9000, cur, "R7 other address ignored");
    bus_read(16'h0017, 8'h00, "R8 other address reads zero");
    // R9: priority load alone, then collision
    @(negedge clk); prio_data = 8'h33; prio_load = 1'b1;
    @(negedge clk); prio_load = 1'b0;
    access(16'hA123, 8'h33, "R9 priority load");
    @(negedge clk);
    prio_data = 8'h55; prio_load = 1'b1;
    bus_addr = 16'h0016; bus_wdata = 8'h44; bus_wr = 1'b1;
    @(negedge clk); prio_load = 1'b0; bus_wr = 1'b0;
    access(16'h8ABC, 8'h55, "R9 priority wins");
    bus_read(16'h0016, 8'h55, "R9 readback");
    // R11: write and access at the same edge
    @(negedge clk);
    bus_addr = 16'h0016; bus_wdata = 8'h66; bus_wr = 1'b1;
    loc_addr = 16'hA000; loc_valid = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; loc_valid = 1'b0;
    check({flash_hit, glob_addr} == expect_map(16'hA000, 8'h55), "R11 old index",
          {flash_hit, glob_addr}, expect_map(16'hA000, 8'h55));
    access(16'hA000, 8'h66, "R11 new index");
    // R1: reset again restores 0xFE
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    access(16'hB111, 8'hFE, "R1 re-reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule